// File: doc/BRIEF.md
# Timer Trigger Output Selector

This block produces the trigger lines that a master timer hands to its slave timers. A slave can use such a line to restart its counter, to start counting, to count only while the line is high, or to take one count per pulse. The selector has no counter of its own. Each cycle the counter core gives it event strobes and level signals. The block picks one source for each of its two outputs and registers the result, so every trigger line comes straight from a flop.

The primary output `trig_a_o` takes a 3-bit source code. The secondary output `trig_b_o` takes a 4-bit code. The lower eight values of that code match the primary encoding. The upper eight values add the levels of compare references 5 and 6 and six edge-pulse sources built from references 4, 5 and 6. Edges are found against a one-cycle registered copy of each of those references. An edge pulse therefore lasts one clock for each change of level.

Top module: `trig_out_sel`

## Requirements
- R1: While `rst_ni` is low, both `trig_a_o` and `trig_b_o` are 0, whatever the inputs.
- R2: Primary code 3'b000 selects the software update-generation strobe `ug_strobe_i`. The output in cycle n+1 equals the strobe in cycle n, and the same one-cycle lag holds for every source below.
- R3: Primary code 3'b001 selects the counter-enable level `cnt_en_i`.
- R4: Primary code 3'b010 selects the update event `update_evt_i`.
- R5: Primary code 3'b011 gives a one-cycle high pulse for every cycle in which `cc1_match_i` is high. The pulse does not depend on whether a channel-1 flag is already set.
- R6: Primary codes 3'b100 to 3'b111 pass compare reference levels 1 to 4, which are `oc_ref_i[0]` to `oc_ref_i[3]`.
- R7: Secondary codes 4'b0000 to 4'b0111 select the same source as the primary code equal to the low three bits.
- R8: Secondary code 4'b1000 passes the reference 5 level (`oc_ref_i[4]`) and 4'b1001 passes the reference 6 level (`oc_ref_i[5]`).
- R9: Secondary code 4'b1010 pulses for one cycle on either edge of reference 4, and 4'b1011 does the same on either edge of reference 6. A level that stays constant gives no pulse.
- R10: Secondary codes 4'b1100 to 4'b1111 pulse on these combinations: ref4 rise OR ref6 rise; ref4 rise OR ref6 fall; ref5 rise OR ref6 rise; ref5 rise OR ref6 fall.
- R11: An edge is a difference from the reference level sampled on the previous clock, and that history is reset to 0. The history updates every cycle whatever code is selected. A code change takes effect at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ug_strobe_i | input | 1 | Software update-generation strobe |
| cnt_en_i | input | 1 | Counter-enable level from the counter core |
| update_evt_i | input | 1 | Update (overflow) event strobe |
| cc1_match_i | input | 1 | Channel-1 capture or compare match strobe |
| oc_ref_i | input | 6 | Compare reference levels 1 to 6, with bit 0 as reference 1 |
| mode_a_i | input | 3 | Source code for the primary output |
| mode_b_i | input | 4 | Source code for the secondary output |
| trig_a_o | output | 1 | Registered primary trigger |
| trig_b_o | output | 1 | Registered secondary trigger |

## Verification
The only internal state is the output flops and the three-bit reference history. A wrong history bit shows up on `trig_b_o` in the next cycle, as a missing pulse or an extra pulse, whenever an edge-pulse code is selected. With a level code selected it stays hidden until an edge code is chosen. A wrong select decode or a wrong lag shows at once on the output under the affected code. The bench therefore drives every code with random, slowly changing references, then switches codes every cycle, and compares both outputs against a behavioural model on each clock.

// File: rtl/trig_sel_pkg.sv
package trig_sel_pkg;
  localparam int unsigned NUM_REF   = 6;
  localparam int unsigned MODE_A_W  = 3;
  localparam int unsigned MODE_B_W  = MODE_A_W + 1;
  localparam int unsigned HIST_BASE = 3;               // refs 4..6 need edge history
  localparam int unsigned HIST_N    = NUM_REF - HIST_BASE;

  typedef enum logic [MODE_A_W-1:0] {
    SRC_SWUPD  = 3'b000,
    SRC_CNTEN  = 3'b001,
    SRC_UPDATE = 3'b010,
    SRC_CMPPLS = 3'b011,
    SRC_REF1   = 3'b100,
    SRC_REF2   = 3'b101,
    SRC_REF3   = 3'b110,
    SRC_REF4   = 3'b111
  } src_a_e;

  typedef enum logic [MODE_B_W-1:0] {
    XSRC_REF5       = 4'b1000,
    XSRC_REF6       = 4'b1001,
    XSRC_EDGE4      = 4'b1010,
    XSRC_EDGE6      = 4'b1011,
    XSRC_R4R_R6R    = 4'b1100,
    XSRC_R4R_R6F    = 4'b1101,
    XSRC_R5R_R6R    = 4'b1110,
    XSRC_R5R_R6F    = 4'b1111
  } src_b_ext_e;
endpackage

// File: rtl/ref_hist.sv
module ref_hist #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] lvl_q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q_o[g] <= 1'b0;
      else         lvl_q_o[g] <= lvl_i[g];
    end
  end
endmodule

// File: rtl/trig_mux_base.sv
module trig_mux_base
  import trig_sel_pkg::*;
(
  input  logic                ug_strobe_i,
  input  logic                cnt_en_i,
  input  logic                update_evt_i,
  input  logic                cc1_match_i,
  input  logic [3:0]          ref_lvl_i,
  input  logic [MODE_A_W-1:0] mode_i,
  output logic                sel_o
);
  always_comb begin
    unique case (src_a_e'(mode_i))
      SRC_SWUPD:  sel_o = ug_strobe_i;
      SRC_CNTEN:  sel_o = cnt_en_i;
      SRC_UPDATE: sel_o = update_evt_i;
      SRC_CMPPLS: sel_o = cc1_match_i;
      SRC_REF1:   sel_o = ref_lvl_i[0];
      SRC_REF2:   sel_o = ref_lvl_i[1];
      SRC_REF3:   sel_o = ref_lvl_i[2];
      default:    sel_o = ref_lvl_i[3];
    endcase
  end
endmodule

// File: rtl/trig_mux_ext.sv
module trig_mux_ext
  import trig_sel_pkg::*;
(
  input  logic                base_i,
  input  logic [HIST_N-1:0]   lvl_i,    // refs 4,5,6
  input  logic [HIST_N-1:0]   lvl_q_i,
  input  logic [MODE_B_W-1:0] mode_i,
  output logic                sel_o
);
  logic [HIST_N-1:0] rise, fall;
  assign rise = lvl_i & ~lvl_q_i;
  assign fall = ~lvl_i & lvl_q_i;

  always_comb begin
    if (!mode_i[MODE_B_W-1]) begin
      sel_o = base_i;
    end else begin
      unique case (src_b_ext_e'(mode_i))
        XSRC_REF5:    sel_o = lvl_i[1];
        XSRC_REF6:    sel_o = lvl_i[2];
        XSRC_EDGE4:   sel_o = rise[0] | fall[0];
        XSRC_EDGE6:   sel_o = rise[2] | fall[2];
        XSRC_R4R_R6R: sel_o = rise[0] | rise[2];
        XSRC_R4R_R6F: sel_o = rise[0] | fall[2];
        XSRC_R5R_R6R: sel_o = rise[1] | rise[2];
        default:      sel_o = rise[1] | fall[2];
      endcase
    end
  end
endmodule

// File: rtl/trig_out_sel.sv
module trig_out_sel
  import trig_sel_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ug_strobe_i,
  input  logic                cnt_en_i,
  input  logic                update_evt_i,
  input  logic                cc1_match_i,
  input  logic [NUM_REF-1:0]  oc_ref_i,
  input  logic [MODE_A_W-1:0] mode_a_i,
  input  logic [MODE_B_W-1:0] mode_b_i,
  output logic                trig_a_o,
  output logic                trig_b_o
);
  logic              sel_a, sel_lo, sel_b;
  logic [HIST_N-1:0] ref_q;
  logic              past_ok_q;

  ref_hist #(.N(HIST_N)) u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (oc_ref_i[NUM_REF-1:HIST_BASE]),
    .lvl_q_o (ref_q)
  );

  trig_mux_base u_mux_a (
    .ug_strobe_i  (ug_strobe_i),
    .cnt_en_i     (cnt_en_i),
    .update_evt_i (update_evt_i),
    .cc1_match_i  (cc1_match_i),
    .ref_lvl_i    (oc_ref_i[3:0]),
    .mode_i       (mode_a_i),
    .sel_o        (sel_a)
  );

  trig_mux_base u_mux_lo (
    .ug_strobe_i  (ug_strobe_i),
    .cnt_en_i     (cnt_en_i),
    .update_evt_i (update_evt_i),
    .cc1_match_i  (cc1_match_i),
    .ref_lvl_i    (oc_ref_i[3:0]),
    .mode_i       (mode_b_i[MODE_A_W-1:0]),
    .sel_o        (sel_lo)
  );

  trig_mux_ext u_mux_b (
    .base_i  (sel_lo),
    .lvl_i   (oc_ref_i[NUM_REF-1:HIST_BASE]),
    .lvl_q_i (ref_q),
    .mode_i  (mode_b_i),
    .sel_o   (sel_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_a_o  <= 1'b0;
      trig_b_o  <= 1'b0;
      past_ok_q <= 1'b0;
    end else begin
      trig_a_o  <= sel_a;
      trig_b_o  <= sel_b;
      past_ok_q <= 1'b1;
    end
  end

  // R1
  rst_low_chk: assert property (@(posedge clk_i) !rst_ni |=> !trig_a_o && !trig_b_o);

  // R4
  upd_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $past(mode_a_i) == 3'b010 |-> trig_a_o == $past(update_evt_i));

  // R5
  cmp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $past(mode_a_i) == 3'b011 |-> trig_a_o == $past(cc1_match_i));

  // R7
  lo_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && !$past(mode_b_i[3]) && $past(mode_b_i[2:0]) == $past(mode_a_i)
    |-> trig_b_o == trig_a_o);

  // R9
  edge4_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $past(mode_b_i) == 4'b1010
    |-> trig_b_o == ($past(oc_ref_i[3]) ^ $past(ref_q[0])));
endmodule

// File: tb/trig_out_sel_bench.sv
module trig_out_sel_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ug, en, upd, cc1;
  logic [5:0] oc_ref;
  logic [2:0] mode_a;
  logic [3:0] mode_b;
  logic       trig_a, trig_b;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit checking = 1'b0;
  bit switching = 1'b0;

  always #5 clk = ~clk;

  trig_out_sel u_trig_out_sel (
    .clk_i(clk), .rst_ni(rst_n), .ug_strobe_i(ug), .cnt_en_i(en),
    .update_evt_i(upd), .cc1_match_i(cc1), .oc_ref_i(oc_ref),
    .mode_a_i(mode_a), .mode_b_i(mode_b), .trig_a_o(trig_a), .trig_b_o(trig_b)
  );

  // behavioural reference model
  logic       exp_a, exp_b;
  logic [5:0] prev_ref;
  string      tag_a, tag_b;

  function automatic logic f_a(int m);
    case (m)
      0: return ug;
      1: return en;
      2: return upd;
      3: return cc1;
      default: return oc_ref[m-4];
    endcase
  endfunction

  function automatic logic f_b(int m);
    bit r4 = oc_ref[3] && !prev_ref[3];
    bit r5 = oc_ref[4] && !prev_ref[4];
    bit r6 = oc_ref[5] && !prev_ref[5];
    bit f6 = !oc_ref[5] && prev_ref[5];
    case (m)
      8:  return oc_ref[4];
      9:  return oc_ref[5];
      10: return oc_ref[3] != prev_ref[3];
      11: return oc_ref[5] != prev_ref[5];
      12: return r4 || r6;
      13: return r4 || f6;
      14: return r5 || r6;
      15: return r5 || f6;
      default: return f_a(m);
    endcase
  endfunction

  function automatic string t_a(int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic string t_b(int m);
    if (m < 8) return "R7";
    if (m < 10) return "R8";
    if (m < 12) return "R9";
    return "R10";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_a = 1'b0; exp_b = 1'b0; prev_ref = '0;
      tag_a = "R1"; tag_b = "R1";
    end else begin
      exp_a = f_a(int'(mode_a));
      exp_b = f_b(int'(mode_b));
      tag_a = switching ? "R11" : t_a(int'(mode_a));
      tag_b = switching ? "R11" : t_b(int'(mode_b));
      prev_ref = oc_ref;
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking && rst_n && !done) begin
      check(tag_a, "trig_a", trig_a, exp_a);
      check(tag_b, "trig_b", trig_b, exp_b);
    end
  end

  task automatic drive_rand();
    ug  = ($urandom_range(3) == 0);
    en  = $urandom_range(1);
    upd = ($urandom_range(3) == 0);
    cc1 = ($urandom_range(2) == 0);
    oc_ref = oc_ref ^ (6'($urandom) & 6'($urandom));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    ug = 1'b1; en = 1'b1; upd = 1'b1; cc1 = 1'b1; oc_ref = '1;
    mode_a = 3'b001; mode_b = 4'b1000;
    repeat (3) @(negedge clk);
    check("R1", "trig_a in reset", trig_a, 1'b0);
    check("R1", "trig_b in reset", trig_b, 1'b0);
    oc_ref = '0;
    @(negedge clk);
    rst_n = 1'b1;
    checking = 1'b1;
    // sweep every code under random stimulus (R2..R10)
    for (int p = 0; p < 16; p++) begin
      mode_a = 3'(p % 8);
      mode_b = 4'(p);
      repeat (60) begin
        @(negedge clk);
        drive_rand();
      end
    end
    // R9: a held level gives a single pulse only
    mode_b = 4'b1010;
    @(negedge clk); oc_ref = '0;
    repeat (3) @(negedge clk);
    oc_ref[3] = 1'b1;
    repeat (5) @(negedge clk);
    oc_ref[3] = 1'b0;
    repeat (3) @(negedge clk);
    // R11: code changes every cycle
    switching = 1'b1;
    repeat (300) begin
      @(negedge clk);
      drive_rand();
      mode_a = 3'($urandom);
      mode_b = 4'($urandom);
    end
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule